// File: doc/BRIEF.md
# Display Interrupt and Line-Flag Controller

This block collects four event sources from a display controller into one interrupt register and drives a single level-sensitive interrupt line. The sources are a hold-valid event, a frame-start event, a scan-line match event and a bus-error event. Hold-valid and bus-error events arrive as single-cycle pulses. Frame start comes as a pulse from the timing generator. The scan-line match event is produced inside the block. It compares the running line count from the timing generator against two trigger lines that software programs.

Software reaches the block through a plain register strobe. It has one write port and one read port, and the read data is registered. Word 0 holds the sticky status bits, the per-source enable bits, the write-one-to-clear bits and trigger line A. Word 1 holds trigger line B. The interrupt output is high while any enabled status bit is set.

Top module: `disp_irq_ctrl`

## Requirements
- R1: Status lives in word 0. Bit 0 is hold-valid, bit 1 is frame start, bit 2 is line match and bit 3 is bus error. A bit sets on the clock edge that samples its event and then stays set. Writes to bits 3:0 do not change status.
- R2: Word 0 bits 7:4 are the enable bits, in the same source order as the status bits. They are read/write.
- R3: Writing 1 to a bit of word 0 bits 11:8 clears the matching status bit, in the same order. Writing 0 there has no effect. These bits always read as 0.
- R4: If an event and a clear reach the same status bit in the same cycle, the bit ends up set.
- R5: Trigger line A is word 0 bits 24:12. Trigger line B is word 1 bits 24:12. The line-match event fires once, on the first cycle where the line count equals a trigger. It does not fire again while the count stays equal.
- R6: `irq_o` is the OR over all sources of (status AND enable). It updates on the same edge as the status and enable registers.
- R7: Synchronous reset clears status, enables and both trigger lines, and drives `irq_o` low.
- R8: `rd_data` gives the addressed word one clock after `rd_addr` is sampled. Unused bits read 0. Words 2 and 3 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Registered read data |
| line_cnt | input | 13 | Current scan line from the timing generator |
| frame_start | input | 1 | Frame-start pulse |
| hold_valid | input | 1 | Hold-valid event pulse |
| bus_err | input | 1 | Bus-error event pulse |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench holds the line count on a trigger value for several cycles. A detector that is level-based instead of edge-based would fire repeatedly, and a clear issued during that hold would be overridden. It also sets two triggers to the same line and to neighbouring lines, and a stuck comparator would miss one of them. It pulses an event in the same cycle as its clear, which catches a design where the clear wins. It writes ones into the status lane and the clear lane and then reads them back, which exposes a writable status bit or a clear bit that reads back as 1.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int NSRC     = 4;
  localparam int NTRIG    = 2;
  localparam int EN_LSB   = 4;
  localparam int CLR_LSB  = 8;
  localparam int LINE_LSB = 12;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_FRAME = 2'd1,
    SRC_LINE  = 2'd2,
    SRC_BUSER = 2'd3
  } src_e;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic d_o,
  output logic q_o
);
  // set has priority over clear
  assign d_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= d_o;
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R3
  clr_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  // R1
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/line_match.sv
module line_match #(
  parameter int LINE_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] trig_i,
  output logic              hit_o
);
  logic eq, eq_q;

  assign eq    = (line_i == trig_i);
  assign hit_o = eq & ~eq_q;

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  // R5
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_o && $stable(line_i) && $stable(trig_i)) |=> !hit_o);
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int LINE_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              frame_start,
  input  logic              hold_valid,
  input  logic              bus_err,
  output logic              irq_o
);
  localparam int TRIG_HI = LINE_LSB + LINE_W;

  logic [NSRC-1:0]   evt, clr, st_d, st_q;
  logic [NSRC-1:0]   en_d, en_q;
  logic [LINE_W-1:0] trig_q [NTRIG];
  logic [NTRIG-1:0]  hit;
  logic              wr_w0;
  logic [DATA_W-1:0] rd_word;

  assign wr_w0 = wr_en && (wr_addr == '0);
  assign clr   = wr_w0 ? wr_data[CLR_LSB +: NSRC] : '0;
  assign en_d  = wr_w0 ? wr_data[EN_LSB +: NSRC] : en_q;

  assign evt[SRC_HOLD]  = hold_valid;
  assign evt[SRC_FRAME] = frame_start;
  assign evt[SRC_LINE]  = |hit;
  assign evt[SRC_BUSER] = bus_err;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_src_latch u_latch (
      .clk   (clk),
      .rst   (rst),
      .set_i (evt[s]),
      .clr_i (clr[s]),
      .d_o   (st_d[s]),
      .q_o   (st_q[s])
    );
  end

  for (genvar t = 0; t < NTRIG; t++) begin : g_trig
    line_match #(.LINE_W(LINE_W)) u_match (
      .clk    (clk),
      .rst    (rst),
      .line_i (line_cnt),
      .trig_i (trig_q[t]),
      .hit_o  (hit[t])
    );

    always_ff @(posedge clk) begin
      if (rst)
        trig_q[t] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(t)))
        trig_q[t] <= wr_data[LINE_LSB +: LINE_W];
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_addr == '0) begin
      rd_word[NSRC-1:0]             = st_q;
      rd_word[EN_LSB +: NSRC]       = en_q;
      rd_word[LINE_LSB +: LINE_W]   = trig_q[0];
    end else if (rd_addr == ADDR_W'(1)) begin
      rd_word[LINE_LSB +: LINE_W]   = trig_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      irq_o   <= 1'b0;
      rd_data <= '0;
    end else begin
      en_q    <= en_d;
      irq_o   <= |(st_d & en_d);
      rd_data <= rd_word;
    end
  end

  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(st_q & en_q));
  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (st_q == '0 && en_q == '0 && !irq_o));
  // R3
  clr_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[CLR_LSB +: NSRC] == '0);
  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:TRIG_HI] == '0);
endmodule

// File: tb/test_disp_irq_ctrl.sv
module test_disp_irq_ctrl;
  logic        clk = 0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic [12:0] line_cnt;
  logic        frame_start, hold_valid, bus_err;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  string req = "R7";

  // behavioural model state
  logic [3:0]  m_st, m_en;
  logic [12:0] m_ta, m_tb;
  bit          m_pa, m_pb;
  logic        m_irq;
  logic [31:0] m_rd;

  always #4 clk = ~clk;

  disp_irq_ctrl i_disp_irq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .line_cnt(line_cnt),
    .frame_start(frame_start), .hold_valid(hold_valid), .bus_err(bus_err),
    .irq_o(irq_o)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_en = 0; m_ta = 0; m_tb = 0; m_pa = 0; m_pb = 0; m_irq = 0; m_rd = 0;
  endtask

  // one cycle: compare outputs, drive inputs, advance model
  task automatic step(input bit we, input logic [1:0] wa, input logic [31:0] wd,
                      input logic [1:0] ra, input logic [12:0] ln,
                      input bit fs, input bit hv, input bit be);
    bit ha, hb, lf;
    logic [3:0] clr;
    @(negedge clk);
    check({req, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
    check({req, " rd"}, rd_data, m_rd);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    line_cnt = ln; frame_start = fs; hold_valid = hv; bus_err = be;
    case (ra)
      2'd0: m_rd = {7'd0, m_ta, 4'd0, m_en, m_st};
      2'd1: m_rd = {7'd0, m_tb, 12'd0};
      default: m_rd = 0;
    endcase
    ha = (ln == m_ta); hb = (ln == m_tb);
    lf = (ha && !m_pa) || (hb && !m_pb);
    m_pa = ha; m_pb = hb;
    clr = (we && wa == 0) ? wd[11:8] : 4'd0;
    m_st = (m_st & ~clr) | {be, lf, fs, hv};
    if (we && wa == 0) begin m_en = wd[7:4]; m_ta = wd[24:12]; end
    if (we && wa == 1) m_tb = wd[24:12];
    m_irq = |(m_st & m_en);
  endtask

  task automatic idle(input logic [1:0] ra, input logic [12:0] ln);
    step(0, 0, 0, ra, ln, 0, 0, 0);
  endtask

  function automatic logic [31:0] w0(input logic [12:0] t, input logic [3:0] en,
                                      input logic [3:0] clr);
    return {7'd0, t, clr, en, 4'd0};
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    line_cnt = 13'h1fff; frame_start = 0; hold_valid = 0; bus_err = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R7: reset state
    @(negedge clk);
    check("R7 rd", rd_data, 32'd0);
    check("R7 irq", {31'd0, irq_o}, 32'd0);

    // R2: enables read/write; R1: status lane not writable
    req = "R2";
    step(1, 0, w0(13'd100, 4'b1010, 4'd0) | 32'hF, 0, 13'h1fff, 0, 0, 0);
    idle(0, 13'h1fff);
    idle(0, 13'h1fff);
    check("R1 R2 rd", rd_data, {7'd0, 13'd100, 4'd0, 4'b1010, 4'd0});

    // R1 + R6: each source sets its own bit
    req = "R1";
    step(0, 0, 0, 0, 13'h1fff, 0, 1, 0);
    idle(0, 13'h1fff);
    step(0, 0, 0, 0, 13'h1fff, 1, 0, 0);
    idle(0, 13'h1fff);
    step(0, 0, 0, 0, 13'h1fff, 0, 0, 1);
    idle(0, 13'h1fff);
    idle(0, 13'h1fff);
    check("R1 rd", rd_data, {7'd0, 13'd100, 4'd0, 4'b1010, 4'b1011});
    req = "R6";
    check("R6 irq", {31'd0, irq_o}, 32'd1);

    // R3: clear lane, zero-write no effect, reads zero
    req = "R3";
    step(1, 0, w0(13'd100, 4'b1010, 4'b0000), 0, 13'h1fff, 0, 0, 0);
    step(1, 0, w0(13'd100, 4'b1010, 4'b1000), 0, 13'h1fff, 0, 0, 0);
    idle(0, 13'h1fff);
    idle(0, 13'h1fff);
    check("R3 rd", rd_data, {7'd0, 13'd100, 4'd0, 4'b1010, 4'b0011});

    // R4: set wins over clear
    req = "R4";
    step(1, 0, w0(13'd100, 4'b1111, 4'b0001), 0, 13'h1fff, 0, 1, 0);
    idle(0, 13'h1fff);
    idle(0, 13'h1fff);
    check("R4 rd", rd_data, {7'd0, 13'd100, 4'd0, 4'b1111, 4'b0011});
    step(1, 0, w0(13'd100, 4'b0000, 4'b1111), 0, 13'h1fff, 0, 0, 0);

    // R5: line match, held count, both triggers
    req = "R5";
    step(1, 1, {7'd0, 13'd102, 12'd0}, 1, 13'h1fff, 0, 0, 0);
    step(1, 0, w0(13'd100, 4'b0100, 4'd0), 0, 13'd98, 0, 0, 0);
    for (int l = 99; l < 105; l++) begin
      idle(0, 13'(l));
      idle(0, 13'(l));
      idle(0, 13'(l));
      step(1, 0, w0(13'd100, 4'b0100, 4'b0100), 0, 13'(l), 0, 0, 0);
    end
    step(1, 1, {7'd0, 13'd7, 12'd0}, 1, 13'd0, 0, 0, 0);
    step(1, 0, w0(13'd7, 4'b0100, 4'b1111), 0, 13'd0, 0, 0, 0);
    for (int l = 0; l < 10; l++) idle(0, 13'(l));

    // R8: unused words read zero, ignore writes
    req = "R8";
    step(1, 2, 32'hFFFF_FFFF, 2, 13'd0, 0, 0, 0);
    step(1, 3, 32'hFFFF_FFFF, 3, 13'd0, 0, 0, 0);
    idle(0, 13'd0);
    idle(1, 13'd0);
    idle(0, 13'd0);

    // mixed random traffic across all requirements
    req = "R1-mix R5-mix R6-mix";
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom_range(0, 5) == 0);
      step(we, 2'($urandom_range(0, 3)),
           {7'd0, 13'($urandom_range(0, 7)), 4'($urandom), 4'($urandom), 4'($urandom)},
           2'($urandom_range(0, 3)), 13'($urandom_range(0, 7)),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 7) == 0));
    end

    // R7: reset mid-run
    req = "R7";
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    wr_en = 0; frame_start = 0; hold_valid = 0; bus_err = 0; rd_addr = 0;
    line_cnt = 13'h1fff;
    model_reset();
    idle(0, 13'h1fff);
    idle(0, 13'h1fff);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule